// File: doc/BRIEF.md
# Aliased Working Register File

This block holds the working registers of a small 8-bit core: thirty-two byte-wide entries, R0 through R31. The core reads two operands per cycle through two combinational byte ports and writes a byte result through one write port. Alongside these it can read any aligned register pair as a 16-bit word and write a 16-bit result to a pair. The even register of a pair carries the low byte and the odd register the high byte.

The three top pairs serve as address pointers and are brought out continuously: X is {R27,R26}, Y is {R29,R28} and Z is {R31,R30}. The same storage also appears at the bottom of the data address space. A data access at address n below 0x20 reads or writes Rn, so a pointer loaded with a small value can reach any register. Data addresses at 0x20 and above are not claimed by this block.

All writes take effect on the rising clock edge. When several write sources name the same register in one cycle, the byte write port has priority, then the pair write port, then the data-space port.

Top module: `gpr_file`

## Requirements
- R1: A synchronous active-high reset clears all 32 registers to 0x00 at the clock edge where it is sampled high. This holds both at start-up and during operation.
- R2: The two byte read ports (rd_a, rd_b) are combinational and independent. Each returns register rd_x_sel, and both may select the same register.
- R3: With wr_en high, register wr_sel takes wr_data at the rising edge. No other register changes because of this port.
- R4: The pair read port returns {R(2p+1), R(2p)} for pair index p = pr_rd_sel.
- R5: With pr_wr_en high, one edge writes pr_wr_data[7:0] to R(2p) and pr_wr_data[15:8] to R(2p+1), where p = pr_wr_sel.
- R6: ptr_x = {R27,R26}, ptr_y = {R29,R28} and ptr_z = {R31,R30} at all times. They follow writes from any port.
- R7: For ds_addr below 0x20, ds_hit is 1 and ds_rdata returns register ds_addr[4:0] combinationally.
- R8: For ds_addr below 0x20 with ds_wr_en high, register ds_addr[4:0] takes ds_wdata at the rising edge.
- R9: For ds_addr of 0x20 or more, ds_hit is 0 and ds_rdata is 0x00. A data-space write at such an address changes no register, even when the low five address bits match a register.
- R10: When the byte or pair write port hits the same register as a data-space write in one cycle, the core port's data is stored.
- R11: When the byte write port hits one register of the pair being written by the pair port, that register takes the byte data. The other register of the pair still takes its lane of the pair data.
- R12: Byte, pair and data-space writes to different registers in the same cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_sel | input | 5 | Register index for byte read port A |
| rd_a_data | output | 8 | Byte read port A data |
| rd_b_sel | input | 5 | Register index for byte read port B |
| rd_b_data | output | 8 | Byte read port B data |
| wr_en | input | 1 | Byte write enable |
| wr_sel | input | 5 | Byte write register index |
| wr_data | input | 8 | Byte write data |
| pr_rd_sel | input | 4 | Pair index for 16-bit read |
| pr_rd_data | output | 16 | Pair read data, odd register in the high byte |
| pr_wr_en | input | 1 | Pair write enable |
| pr_wr_sel | input | 4 | Pair index for 16-bit write |
| pr_wr_data | input | 16 | Pair write data, low byte to the even register |
| ptr_x | output | 16 | X pointer {R27,R26} |
| ptr_y | output | 16 | Y pointer {R29,R28} |
| ptr_z | output | 16 | Z pointer {R31,R30} |
| ds_addr | input | 16 | Data-space address |
| ds_wr_en | input | 1 | Data-space write enable |
| ds_wdata | input | 8 | Data-space write data |
| ds_rdata | output | 8 | Data-space read data, zero outside the window |
| ds_hit | output | 1 | Data-space address falls in the register window |

## Verification
Every cycle, the assertions check four things. The first is that each write source lands where it should on the next edge, honouring the byte-over-pair-over-data-space priority. The second is that the pointer outputs agree with the pair read port at the matching index. The third is that an address outside the window yields no hit, zero data and no register change. The fourth is that the file is clear right after reset. Only the bench's scenarios can show the full picture of read-back values across all 32 entries, the lane placement of pair writes seen through the byte ports, and a data-space access reaching a register through the same storage the core uses.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  localparam int DEF_NUM_REGS  = 32;
  localparam int DEF_DATA_W    = 8;
  localparam int DEF_DS_ADDR_W = 16;

  // Which source updates one register this cycle, lowest priority first
  typedef enum logic [1:0] {
    WS_NONE = 2'd0,
    WS_DS   = 2'd1,
    WS_PAIR = 2'd2,
    WS_BYTE = 2'd3
  } wsrc_e;

endpackage

// File: rtl/gpr_write_ctrl.sv
module gpr_write_ctrl
  import gpr_pkg::*;
#(
  parameter int NUM_REGS = DEF_NUM_REGS,
  parameter int DATA_W   = DEF_DATA_W,
  localparam int RIDX_W  = $clog2(NUM_REGS),
  localparam int PIDX_W  = RIDX_W - 1,
  localparam int PAIR_W  = 2 * DATA_W
) (
  input  logic                       byte_en,
  input  logic [RIDX_W-1:0]          byte_sel,
  input  logic [DATA_W-1:0]          byte_data,
  input  logic                       pair_en,
  input  logic [PIDX_W-1:0]          pair_sel,
  input  logic [PAIR_W-1:0]          pair_data,
  input  logic                       ds_en,
  input  logic [RIDX_W-1:0]          ds_sel,
  input  logic [DATA_W-1:0]          ds_data,
  output logic [NUM_REGS-1:0]        we,
  output logic [NUM_REGS*DATA_W-1:0] wd_flat
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    localparam logic [RIDX_W-1:0] IDX  = RIDX_W'(i);
    localparam int                LANE = i % 2;
    wsrc_e src;

    // Later assignments override earlier ones: byte > pair > data space
    always_comb begin
      src = WS_NONE;
      if (ds_en && ds_sel == IDX)                     src = WS_DS;
      if (pair_en && pair_sel == IDX[RIDX_W-1:1])     src = WS_PAIR;
      if (byte_en && byte_sel == IDX)                 src = WS_BYTE;
    end

    assign we[i] = (src != WS_NONE);

    always_comb begin
      case (src)
        WS_BYTE: wd_flat[i*DATA_W +: DATA_W] = byte_data;
        WS_PAIR: wd_flat[i*DATA_W +: DATA_W] = pair_data[LANE*DATA_W +: DATA_W];
        default: wd_flat[i*DATA_W +: DATA_W] = ds_data;
      endcase
    end
  end

endmodule

// File: rtl/gpr_storage.sv
module gpr_storage
  import gpr_pkg::*;
#(
  parameter int NUM_REGS = DEF_NUM_REGS,
  parameter int DATA_W   = DEF_DATA_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_REGS-1:0]        we,
  input  logic [NUM_REGS*DATA_W-1:0] wd_flat,
  output logic [NUM_REGS*DATA_W-1:0] q_flat
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)        q_flat[i*DATA_W +: DATA_W] <= '0;
      else if (we[i]) q_flat[i*DATA_W +: DATA_W] <= wd_flat[i*DATA_W +: DATA_W];
    end
  end

  // R1: the first sampled cycle out of reset sees an all-zero file
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> q_flat == '0);

endmodule

// File: rtl/gpr_read_mux.sv
module gpr_read_mux #(
  parameter int ENTRIES = 32,
  parameter int WIDTH   = 8,
  localparam int SEL_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES*WIDTH-1:0] flat,
  input  logic [SEL_W-1:0]         sel,
  output logic [WIDTH-1:0]         data
);

  logic [WIDTH-1:0] ent [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_view
    assign ent[g] = flat[g*WIDTH +: WIDTH];
  end

  assign data = ent[sel];

endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
#(
  parameter int NUM_REGS  = DEF_NUM_REGS,
  parameter int DATA_W    = DEF_DATA_W,
  parameter int DS_ADDR_W = DEF_DS_ADDR_W,
  parameter int X_LO      = 26,
  parameter int Y_LO      = 28,
  parameter int Z_LO      = 30,
  localparam int RIDX_W    = $clog2(NUM_REGS),
  localparam int PIDX_W    = RIDX_W - 1,
  localparam int NUM_PAIRS = NUM_REGS / 2,
  localparam int PAIR_W    = 2 * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [RIDX_W-1:0]    rd_a_sel,
  output logic [DATA_W-1:0]    rd_a_data,
  input  logic [RIDX_W-1:0]    rd_b_sel,
  output logic [DATA_W-1:0]    rd_b_data,
  input  logic                 wr_en,
  input  logic [RIDX_W-1:0]    wr_sel,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [PIDX_W-1:0]    pr_rd_sel,
  output logic [PAIR_W-1:0]    pr_rd_data,
  input  logic                 pr_wr_en,
  input  logic [PIDX_W-1:0]    pr_wr_sel,
  input  logic [PAIR_W-1:0]    pr_wr_data,
  output logic [PAIR_W-1:0]    ptr_x,
  output logic [PAIR_W-1:0]    ptr_y,
  output logic [PAIR_W-1:0]    ptr_z,
  input  logic [DS_ADDR_W-1:0] ds_addr,
  input  logic                 ds_wr_en,
  input  logic [DATA_W-1:0]    ds_wdata,
  output logic [DATA_W-1:0]    ds_rdata,
  output logic                 ds_hit
);

  logic [NUM_REGS*DATA_W-1:0] q_flat;
  logic [NUM_REGS*DATA_W-1:0] wd_flat;
  logic [NUM_REGS-1:0]        we;
  logic [RIDX_W-1:0]          ds_idx;
  logic [DATA_W-1:0]          ds_mux_data;

  // Register window: all address bits above the index field are zero
  assign ds_hit = (ds_addr[DS_ADDR_W-1:RIDX_W] == '0);
  assign ds_idx = ds_addr[RIDX_W-1:0];

  gpr_write_ctrl #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_wctl (
    .byte_en  (wr_en),
    .byte_sel (wr_sel),
    .byte_data(wr_data),
    .pair_en  (pr_wr_en),
    .pair_sel (pr_wr_sel),
    .pair_data(pr_wr_data),
    .ds_en    (ds_wr_en && ds_hit),
    .ds_sel   (ds_idx),
    .ds_data  (ds_wdata),
    .we       (we),
    .wd_flat  (wd_flat)
  );

  gpr_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .we     (we),
    .wd_flat(wd_flat),
    .q_flat (q_flat)
  );

  gpr_read_mux #(.ENTRIES(NUM_REGS), .WIDTH(DATA_W)) u_rd_a (
    .flat(q_flat), .sel(rd_a_sel), .data(rd_a_data));

  gpr_read_mux #(.ENTRIES(NUM_REGS), .WIDTH(DATA_W)) u_rd_b (
    .flat(q_flat), .sel(rd_b_sel), .data(rd_b_data));

  gpr_read_mux #(.ENTRIES(NUM_REGS), .WIDTH(DATA_W)) u_rd_ds (
    .flat(q_flat), .sel(ds_idx), .data(ds_mux_data));

  // Pairs are the same flat storage viewed as half as many double-width entries
  gpr_read_mux #(.ENTRIES(NUM_PAIRS), .WIDTH(PAIR_W)) u_rd_pair (
    .flat(q_flat), .sel(pr_rd_sel), .data(pr_rd_data));

  assign ds_rdata = ds_hit ? ds_mux_data : '0;

  assign ptr_x = q_flat[X_LO*DATA_W +: PAIR_W];
  assign ptr_y = q_flat[Y_LO*DATA_W +: PAIR_W];
  assign ptr_z = q_flat[Z_LO*DATA_W +: PAIR_W];

  // ---------------- assertions ----------------
  function automatic logic [DATA_W-1:0] byte_at(input logic [NUM_REGS*DATA_W-1:0] f,
                                                input logic [RIDX_W-1:0] k);
    return f[k*DATA_W +: DATA_W];
  endfunction

  function automatic logic [PAIR_W-1:0] pair_at(input logic [NUM_REGS*DATA_W-1:0] f,
                                                input logic [PIDX_W-1:0] k);
    return f[k*PAIR_W +: PAIR_W];
  endfunction

  assert_byte_write_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> byte_at(q_flat, $past(wr_sel)) == $past(wr_data));

  assert_pair_write_R5: assert property (@(posedge clk) disable iff (rst)
    pr_wr_en && !(wr_en && wr_sel[RIDX_W-1:1] == pr_wr_sel)
    |=> pair_at(q_flat, $past(pr_wr_sel)) == $past(pr_wr_data));

  assert_ptr_x_R6: assert property (@(posedge clk) disable iff (rst)
    pr_rd_sel == PIDX_W'(X_LO / 2) |-> pr_rd_data == ptr_x);
  assert_ptr_y_R6: assert property (@(posedge clk) disable iff (rst)
    pr_rd_sel == PIDX_W'(Y_LO / 2) |-> pr_rd_data == ptr_y);
  assert_ptr_z_R6: assert property (@(posedge clk) disable iff (rst)
    pr_rd_sel == PIDX_W'(Z_LO / 2) |-> pr_rd_data == ptr_z);

  assert_ds_write_R8: assert property (@(posedge clk) disable iff (rst)
    ds_wr_en && ds_hit && !(wr_en && wr_sel == ds_idx)
    && !(pr_wr_en && pr_wr_sel == ds_idx[RIDX_W-1:1])
    |=> byte_at(q_flat, $past(ds_idx)) == $past(ds_wdata));

  assert_ds_miss_read_R9: assert property (@(posedge clk) disable iff (rst)
    ds_addr >= DS_ADDR_W'(NUM_REGS) |-> !ds_hit && ds_rdata == '0);

  assert_ds_miss_write_R9: assert property (@(posedge clk) disable iff (rst)
    ds_wr_en && !ds_hit && !wr_en && !pr_wr_en |=> $stable(q_flat));

  assert_core_beats_ds_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en && ds_wr_en && ds_hit && ds_idx == wr_sel
    |=> byte_at(q_flat, $past(ds_idx)) == $past(wr_data));

  assert_byte_beats_pair_R11: assert property (@(posedge clk) disable iff (rst)
    wr_en && pr_wr_en && wr_sel[RIDX_W-1:1] == pr_wr_sel
    |=> byte_at(q_flat, $past(wr_sel ^ RIDX_W'(1))) ==
        ($past(wr_sel[0]) ? $past(pr_wr_data[DATA_W-1:0])
                          : $past(pr_wr_data[PAIR_W-1:DATA_W])));

endmodule

// File: tb/gpr_file_test.sv
module gpr_file_test;

  localparam int P_A = 0, P_B = 1, P_P = 2, P_X = 3, P_Y = 4, P_Z = 5, P_D = 6, P_H = 7;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rd_a_sel, rd_b_sel, wr_sel;
  logic [7:0]  rd_a_data, rd_b_data, wr_data, ds_wdata, ds_rdata;
  logic        wr_en, pr_wr_en, ds_wr_en, ds_hit;
  logic [3:0]  pr_rd_sel, pr_wr_sel;
  logic [15:0] pr_rd_data, pr_wr_data, ptr_x, ptr_y, ptr_z, ds_addr;

  always #5 clk = ~clk;

  gpr_file uut (
    .clk(clk), .rst(rst),
    .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
    .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pr_rd_sel(pr_rd_sel), .pr_rd_data(pr_rd_data),
    .pr_wr_en(pr_wr_en), .pr_wr_sel(pr_wr_sel), .pr_wr_data(pr_wr_data),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
    .ds_addr(ds_addr), .ds_wr_en(ds_wr_en), .ds_wdata(ds_wdata),
    .ds_rdata(ds_rdata), .ds_hit(ds_hit)
  );

  typedef struct {
    int          port;
    int          sel;
    logic [15:0] exp;
    string       req;
  } exp_t;

  exp_t       sbq[$];
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done  = 0;
  logic [7:0] model [32];

  function automatic logic [15:0] observe(input int port);
    case (port)
      P_A:     return {8'h00, rd_a_data};
      P_B:     return {8'h00, rd_b_data};
      P_P:     return pr_rd_data;
      P_X:     return ptr_x;
      P_Y:     return ptr_y;
      P_Z:     return ptr_z;
      P_D:     return {8'h00, ds_rdata};
      default: return {15'h0000, ds_hit};
    endcase
  endfunction

  // Monitor: compares queued expectations late in the low clock phase
  initial begin
    forever begin
      @(negedge clk);
      #4;
      while (sbq.size() > 0) begin
        exp_t e;
        logic [15:0] got;
        e = sbq.pop_front();
        got = observe(e.port);
        n_vec++;
        if (got !== e.exp) begin
          n_bad++;
          $display("FAIL %s port %0d sel %0d: actual %h expected %h",
                   e.req, e.port, e.sel, got, e.exp);
        end
      end
    end
  end

  task automatic next();
    @(negedge clk);
    wr_en = 1'b0; pr_wr_en = 1'b0; ds_wr_en = 1'b0;
  endtask

  task automatic chk(input int port, input int sel, input logic [15:0] exp, input string req);
    case (port)
      P_A: rd_a_sel  = 5'(sel);
      P_B: rd_b_sel  = 5'(sel);
      P_P: pr_rd_sel = 4'(sel);
      P_D, P_H: ds_addr = 16'(sel);
      default: ;
    endcase
    sbq.push_back('{port, sel, exp, req});
  endtask

  // One write cycle; the model applies data space, then pair, then byte
  task automatic drive(input bit be, input int bi, input logic [7:0] bv,
                       input bit pe, input int pi, input logic [15:0] pv,
                       input bit de, input int da, input logic [7:0] dv);
    next();
    wr_en = be; wr_sel = 5'(bi); wr_data = bv;
    pr_wr_en = pe; pr_wr_sel = 4'(pi); pr_wr_data = pv;
    ds_wr_en = de; ds_addr = 16'(da); ds_wdata = dv;
    if (de && da < 32) model[da] = dv;
    if (pe) begin model[2*pi] = pv[7:0]; model[2*pi+1] = pv[15:8]; end
    if (be) model[bi] = bv;
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 32; i++) begin
      next();
      chk(P_A, i, {8'h00, model[i]}, req);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    wr_en = 0; pr_wr_en = 0; ds_wr_en = 0;
    rd_a_sel = 0; rd_b_sel = 0; wr_sel = 0; wr_data = 0;
    pr_rd_sel = 0; pr_wr_sel = 0; pr_wr_data = 0;
    ds_addr = 0; ds_wdata = 0;
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: every register reads zero after reset
    check_all("R1");

    // R3: byte writes with a distinct value per register
    for (int i = 0; i < 32; i++) drive(1, i, 8'(i * 37 + 11), 0, 0, 0, 0, 0, 0);
    // R3 on port A, R2 on port B walking the other way
    for (int i = 0; i < 32; i++) begin
      next();
      chk(P_A, i, {8'h00, model[i]}, "R3");
      chk(P_B, 31 - i, {8'h00, model[31 - i]}, "R2");
    end
    // R2: both ports on the same register
    next();
    chk(P_A, 9, {8'h00, model[9]}, "R2");
    chk(P_B, 9, {8'h00, model[9]}, "R2");

    // R4/R5: pair writes, read back as pairs and as bytes
    for (int p = 0; p < 16; p++) drive(0, 0, 0, 1, p, 16'hA05F + 16'(p * 16'h0111), 0, 0, 0);
    for (int p = 0; p < 16; p++) begin
      next();
      chk(P_P, p, {model[2*p+1], model[2*p]}, "R4");
      chk(P_A, 2*p, {8'h00, model[2*p]}, "R5");
      chk(P_B, 2*p+1, {8'h00, model[2*p+1]}, "R5");
    end

    // R6: pointer pairs
    drive(0, 0, 0, 1, 13, 16'h1234, 0, 0, 0);
    drive(0, 0, 0, 1, 14, 16'h5678, 0, 0, 0);
    drive(0, 0, 0, 1, 15, 16'h9ABC, 0, 0, 0);
    next();
    chk(P_X, 0, 16'h1234, "R6");
    chk(P_Y, 0, 16'h5678, "R6");
    chk(P_Z, 0, 16'h9ABC, "R6");
    drive(1, 26, 8'h55, 0, 0, 0, 0, 0, 0);
    next();
    chk(P_X, 0, 16'h1255, "R6");

    // R7: data-space reads inside the window
    foreach (model[i]) if (i == 0 || i == 5 || i == 31) begin
      next();
      chk(P_D, i, {8'h00, model[i]}, "R7");
      chk(P_H, i, 16'h0001, "R7");
    end

    // R8: data-space writes inside the window
    drive(0, 0, 0, 0, 0, 0, 1, 7, 8'hC3);
    next();
    chk(P_A, 7, 16'h00C3, "R8");
    drive(0, 0, 0, 0, 0, 0, 1, 30, 8'h6E);
    next();
    chk(P_Z, 0, {model[31], 8'h6E}, "R8");

    // R9: outside the window
    next();
    chk(P_H, 32, 16'h0000, "R9");
    chk(P_D, 32, 16'h0000, "R9");
    next();
    chk(P_H, 16'h0105, 16'h0000, "R9");
    chk(P_D, 16'h0105, 16'h0000, "R9");
    drive(0, 0, 0, 0, 0, 0, 1, 16'h0025, 8'hEE);
    next();
    chk(P_A, 5, {8'h00, model[5]}, "R9");
    drive(0, 0, 0, 0, 0, 0, 1, 16'h0105, 8'hEE);
    next();
    chk(P_A, 5, {8'h00, model[5]}, "R9");

    // R10: core ports beat data space
    drive(1, 10, 8'h11, 0, 0, 0, 1, 10, 8'h22);
    next();
    chk(P_A, 10, 16'h0011, "R10");
    drive(0, 0, 0, 1, 6, 16'h4C3B, 1, 13, 8'h99);
    next();
    chk(P_P, 6, 16'h4C3B, "R10");

    // R11: byte beats pair on the shared register only
    drive(1, 20, 8'h77, 1, 10, 16'hBEEF, 0, 0, 0);
    next();
    chk(P_A, 20, 16'h0077, "R11");
    chk(P_B, 21, 16'h00BE, "R11");
    drive(1, 23, 8'h0D, 1, 11, 16'hCAFE, 0, 0, 0);
    next();
    chk(P_P, 11, 16'h0DFE, "R11");

    // R12: three sources, three different registers, one edge
    drive(1, 3, 8'h3A, 1, 4, 16'h9182, 1, 17, 8'h5D);
    next();
    chk(P_A, 3, 16'h003A, "R12");
    chk(P_P, 4, 16'h9182, "R12");
    chk(P_B, 17, 16'h005D, "R12");

    // R1: reset during operation
    next();
    rst = 1'b1;
    next();
    rst = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    check_all("R1");
    next();
    chk(P_Z, 0, 16'h0000, "R1");

    next();
    next();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule